// File: doc/BRIEF.md
# Receiver Error Flag and Status Unit

This unit sits behind the line decoder of a digital audio receiver. It merges the receiver's error sources into one error output. A host uses that output as a mute or interrupt request. The unit also keeps sticky status bits that the host clears by reading them. The error sources are:

- loss of clock lock (a level);
- per-subframe strobes for parity, biphase and frame-length errors;
- a change in a 6-bit receiver status word that is sampled once per frame.

Each source can be masked. The parallel/serial mode select decides which sources count. After the last active source goes away, the output stays high for a selectable number of frames.

The stretch is produced by a three-state machine:

- `ST_IDLE`: the output is low.
- `ST_ACTIVE`: a source is present in this cycle.
- `ST_HOLD`: no source is present, and the machine counts frame strobes.

The transitions are:

- *raise*: any state goes to `ST_ACTIVE` when a source is present.
- *release*: `ST_ACTIVE` goes to `ST_HOLD` when no source is present.
- *expire*: `ST_HOLD` goes to `ST_IDLE` on the frame strobe that completes the hold count.
- *quench*: any state goes to `ST_IDLE` while the clock recovery is switched off.

Top module: `rx_err_status`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is 0.
- R2: With `serial_mode`=1, each source below drives `err_out` high in the cycle after it is present, unless its mask turns it off:
  - `unlock` is never masked;
  - a parity, biphase or frame-length strobe counts only while `par_report_en`=1;
  - a set `stc_flag` counts only while `stc_report_en`=1.
- R3: With `serial_mode`=0, `err_out` follows `unlock` and the three error strobes, whatever the mask inputs say. `stc_flag` has no effect on `err_out`.
- R4: After the last cycle with a source present, `err_out` stays high until N frame strobes have arrived in cycles with no source present. It falls in the cycle after the Nth such strobe. N = 512 << `hold_sel`, so 00 gives 512, 01 gives 1024, 10 gives 2048 and 11 gives 4096.
- R5: While `pll_off`=1, `err_out` is 0. Any hold in progress is discarded.
- R6: `stc_flag` sets in the cycle after a frame strobe whose `stat_word` differs from the value sampled at the previous frame strobe.
- R7: The comparisons made at the first 192 frame strobes after reset never set `stc_flag`.
- R8: A pulse on `rd_stat1` clears `stc_flag`. If a new set arrives in the same cycle, the flag stays 1.
- R9: Each sticky bit sets as follows, and all of them clear on `rd_stat2`, with a same-cycle set winning:
  - `st_par`, `st_bip` and `st_len` set on their strobe, independent of `par_report_en`;
  - `st_valid` sets on a frame strobe while `valid_bit`=1;
  - `st_unlock` sets in any cycle in which `unlock`=1.
- R10: When status change is the only source, the hold of R4 starts from the `rd_stat1` read that clears `stc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per frame |
| par_err_stb | input | 1 | Parity error seen in a subframe |
| bip_err_stb | input | 1 | Biphase error seen in a subframe |
| len_err_stb | input | 1 | Frame-length error seen in a subframe |
| unlock | input | 1 | Clock recovery out of lock (level) |
| valid_bit | input | 1 | Received validity bit |
| stat_word | input | 6 | Receiver status word, sampled on frame strobes |
| par_report_en | input | 1 | 1 lets the parity, biphase and length errors reach `err_out` |
| stc_report_en | input | 1 | 1 lets the status change reach `err_out` |
| hold_sel | input | 2 | Selects the hold length (512 << value frames) |
| serial_mode | input | 1 | 1 selects serial mode, 0 selects parallel mode |
| pll_off | input | 1 | Clock recovery switched off |
| rd_stat1 | input | 1 | Read strobe for status register 1 (clears `stc_flag`) |
| rd_stat2 | input | 1 | Read strobe for status register 2 (clears the sticky bits) |
| err_out | output | 1 | Combined, stretched error output |
| stc_flag | output | 1 | Status-change flag |
| st_par | output | 1 | Sticky parity error |
| st_bip | output | 1 | Sticky biphase error |
| st_len | output | 1 | Sticky frame-length error |
| st_valid | output | 1 | Sticky validity bit |
| st_unlock | output | 1 | Sticky unlock |

## Verification
Two events can meet in the same cycle: a host read that clears a flag, and a fresh set of that same flag. The status-change flag is one case. Each sticky bit is another.

The bench provokes both cases:

- It drives `rd_stat1` exactly on the frame strobe at which the status word changes.
- It pulses `rd_stat2` together with a parity strobe.

In both cases the flag must read 1 afterwards. The same pairing applies to the hold machine. A new source that arrives during the hold must restart the count, and a behavioural frame-countdown model judges this on every clock.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } hold_state_t;

    localparam int STICKY_PAR    = 0;
    localparam int STICKY_BIP    = 1;
    localparam int STICKY_LEN    = 2;
    localparam int STICKY_VALID  = 3;
    localparam int STICKY_UNLOCK = 4;
    localparam int STICKY_COUNT  = 5;
endpackage

// File: rtl/err_hold_fsm.sv
module err_hold_fsm
    import rx_err_pkg::*;
#(
    parameter int BASE_HOLD = 512,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic             frame_stb,
    input  logic             pll_off,
    input  logic [SEL_W-1:0] hold_sel,
    output logic             err_out
);
    localparam int MAX_HOLD = BASE_HOLD << ((1 << SEL_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HOLD) + 1;

    hold_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(BASE_HOLD) << hold_sel;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pll_off) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (src) begin
            state_d = ST_ACTIVE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ACTIVE: begin
                    state_d = ST_HOLD;
                    cnt_d   = {{(CNT_W-1){1'b0}}, frame_stb};
                end
                ST_HOLD: begin
                    if (frame_stb) begin
                        if (cnt_q >= limit - 1'b1) begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        err_out = (state_q != ST_IDLE) && !pll_off;
    end

    // R4: a source present while running puts the machine in ST_ACTIVE
    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (src && !pll_off) |=> (state_q == ST_ACTIVE));
    // R5: switching off the clock recovery returns the machine to idle
    a_r5_quench: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |=> (state_q == ST_IDLE));
    // R4: the hold counter never leaves its range
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q < CNT_W'(MAX_HOLD)));
endmodule

// File: rtl/stc_detect.sv
module stc_detect #(
    parameter int WORD_W       = 6,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [WORD_W-1:0] stat_word,
    input  logic              rd_clr,
    output logic              stc_flag
);
    localparam int BLK_W = $clog2(BLOCK_FRAMES + 1);

    logic [BLK_W-1:0]  blk_cnt;
    logic [WORD_W-1:0] prev_q;
    logic              armed;
    logic              set_now;

    assign armed   = (blk_cnt == BLK_W'(BLOCK_FRAMES));
    assign set_now = frame_stb && armed && (stat_word != prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cnt  <= '0;
            prev_q   <= '0;
            stc_flag <= 1'b0;
        end else begin
            if (frame_stb) begin
                prev_q <= stat_word;
                if (!armed) blk_cnt <= blk_cnt + 1'b1;
            end
            stc_flag <= set_now || (stc_flag && !rd_clr);
        end
    end

    // R7: nothing can set the flag before the first block has passed
    a_r7_first_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !stc_flag) |=> !stc_flag);
    // R8: a read outside a frame strobe always clears the flag
    a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !frame_stb) |=> !stc_flag);
    // R6: the flag only rises after a frame strobe
    a_r6_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stc_flag) |-> $past(frame_stb));
endmodule

// File: rtl/sticky_bits.sv
module sticky_bits #(
    parameter int NBITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_vec,
    input  logic             rd_clr,
    output logic [NBITS-1:0] st_vec
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_vec[i] <= 1'b0;
            else        st_vec[i] <= set_vec[i] || (st_vec[i] && !rd_clr);
        end

        // R9: a set always lands, even against a same-cycle read
        a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> st_vec[i]);
        // R9: the bit holds until read
        a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (st_vec[i] && !rd_clr) |=> st_vec[i]);
    end
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_err_pkg::*;
#(
    parameter int WORD_W       = 6,
    parameter int BLOCK_FRAMES = 192,
    parameter int BASE_HOLD    = 512,
    parameter int SEL_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              par_err_stb,
    input  logic              bip_err_stb,
    input  logic              len_err_stb,
    input  logic              unlock,
    input  logic              valid_bit,
    input  logic [WORD_W-1:0] stat_word,
    input  logic              par_report_en,
    input  logic              stc_report_en,
    input  logic [SEL_W-1:0]  hold_sel,
    input  logic              serial_mode,
    input  logic              pll_off,
    input  logic              rd_stat1,
    input  logic              rd_stat2,
    output logic              err_out,
    output logic              stc_flag,
    output logic              st_par,
    output logic              st_bip,
    output logic              st_len,
    output logic              st_valid,
    output logic              st_unlock
);
    logic                    line_err;
    logic                    src;
    logic [STICKY_COUNT-1:0] set_vec;
    logic [STICKY_COUNT-1:0] st_vec;

    assign line_err = par_err_stb | bip_err_stb | len_err_stb;
    assign src = unlock |
                 (serial_mode ? ((par_report_en & line_err) | (stc_report_en & stc_flag))
                              : line_err);

    err_hold_fsm #(.BASE_HOLD(BASE_HOLD), .SEL_W(SEL_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .src(src), .frame_stb(frame_stb),
        .pll_off(pll_off), .hold_sel(hold_sel), .err_out(err_out)
    );

    stc_detect #(.WORD_W(WORD_W), .BLOCK_FRAMES(BLOCK_FRAMES)) u_stc (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .stat_word(stat_word),
        .rd_clr(rd_stat1), .stc_flag(stc_flag)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[STICKY_PAR]    = par_err_stb;
        set_vec[STICKY_BIP]    = bip_err_stb;
        set_vec[STICKY_LEN]    = len_err_stb;
        set_vec[STICKY_VALID]  = frame_stb & valid_bit;
        set_vec[STICKY_UNLOCK] = unlock;
    end

    sticky_bits #(.NBITS(STICKY_COUNT)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_stat2), .st_vec(st_vec)
    );

    assign st_par    = st_vec[STICKY_PAR];
    assign st_bip    = st_vec[STICKY_BIP];
    assign st_len    = st_vec[STICKY_LEN];
    assign st_valid  = st_vec[STICKY_VALID];
    assign st_unlock = st_vec[STICKY_UNLOCK];

    // R2: unlock reaches the output whatever the masks say
    a_r2_unlock_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && !pll_off) |=> (err_out || pll_off));
    // R3: in parallel mode a line error raises the output regardless of masks
    a_r3_parallel_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && line_err && !pll_off) |=> (err_out || pll_off));
    // R5: the output is low while the clock recovery is off
    a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        pll_off |-> !err_out);
endmodule

// File: tb/sim_rx_err_status.sv
module sim_rx_err_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       par_err_stb = 1'b0, bip_err_stb = 1'b0, len_err_stb = 1'b0;
    logic       unlock = 1'b0, valid_bit = 1'b0;
    logic [5:0] stat_word = 6'd0;
    logic       par_report_en = 1'b1, stc_report_en = 1'b1;
    logic [1:0] hold_sel = 2'd0;
    logic       serial_mode = 1'b1, pll_off = 1'b0;
    logic       rd_stat1 = 1'b0, rd_stat2 = 1'b0;
    logic       err_out, stc_flag, st_par, st_bip, st_len, st_valid, st_unlock;

    int    total = 0;
    int    bad = 0;
    int    fc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    rx_err_status u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .par_err_stb(par_err_stb), .bip_err_stb(bip_err_stb), .len_err_stb(len_err_stb),
        .unlock(unlock), .valid_bit(valid_bit), .stat_word(stat_word),
        .par_report_en(par_report_en), .stc_report_en(stc_report_en),
        .hold_sel(hold_sel), .serial_mode(serial_mode), .pll_off(pll_off),
        .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
        .err_out(err_out), .stc_flag(stc_flag), .st_par(st_par), .st_bip(st_bip),
        .st_len(st_len), .st_valid(st_valid), .st_unlock(st_unlock)
    );

    // behavioural reference
    int   m_rem = 0;
    int   m_frames = 0;
    logic [5:0] m_prev = 6'd0;
    bit   m_stc = 0, m_par = 0, m_bip = 0, m_len = 0, m_val = 0, m_unl = 0;

    task automatic chk(input bit act, input bit exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit lerr, src, nset;
        if (!rst_n) begin
            m_rem = 0; m_frames = 0; m_prev = 6'd0;
            m_stc = 0; m_par = 0; m_bip = 0; m_len = 0; m_val = 0; m_unl = 0;
        end else begin
            lerr = par_err_stb | bip_err_stb | len_err_stb;
            src = unlock | (serial_mode ? ((par_report_en & lerr) | (stc_report_en & m_stc)) : lerr);
            if (pll_off) m_rem = 0;
            else if (src) m_rem = 512 << hold_sel;
            else if (m_rem > 0 && frame_stb) m_rem = m_rem - 1;
            nset = frame_stb && (m_frames >= 192) && (stat_word != m_prev);
            m_stc = nset | (m_stc & !rd_stat1);
            if (frame_stb) begin
                m_prev = stat_word;
                if (m_frames < 192) m_frames++;
            end
            m_par = par_err_stb | (m_par & !rd_stat2);
            m_bip = bip_err_stb | (m_bip & !rd_stat2);
            m_len = len_err_stb | (m_len & !rd_stat2);
            m_val = (frame_stb & valid_bit) | (m_val & !rd_stat2);
            m_unl = unlock | (m_unl & !rd_stat2);
        end
        #5;
        if (!done) begin
            chk(err_out, (m_rem > 0) && !pll_off, "err_out");
            chk(stc_flag, m_stc, "stc_flag");
            chk(st_par, m_par, "st_par");
            chk(st_bip, m_bip, "st_bip");
            chk(st_len, m_len, "st_len");
            chk(st_valid, m_val, "st_valid");
            chk(st_unlock, m_unl, "st_unlock");
        end
    end

    task automatic step(input bit p, input bit b, input bit f, input bit r1, input bit r2);
        @(negedge clk);
        par_err_stb = p; bip_err_stb = b; len_err_stb = f;
        rd_stat1 = r1; rd_stat2 = r2;
        frame_stb = (fc % 4 == 3);
        fc++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic settle();
        @(posedge clk);
        #6;
    endtask

    task automatic sync_frame();
        while (fc % 4 != 3) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        settle();
        chk(err_out, 0, "R1 err_out in reset");
        chk(stc_flag, 0, "R1 stc in reset");
        @(negedge clk); rst_n = 1'b1;
        settle();
        chk(err_out | st_par | st_unlock | st_valid, 0, "R1 outputs after reset");

        cur_req = "R7";
        run(8); stat_word = 6'h15; run(12);
        chk(stc_flag, 0, "R7 change inside first block");
        stat_word = 6'h2A; run(800);
        chk(stc_flag, 0, "R7 still clear after block");

        cur_req = "R6";
        sync_frame(); stat_word = 6'h07; step(0, 0, 0, 0, 0); settle();
        chk(stc_flag, 1, "R6 flag set on change");
        cur_req = "R10";
        step(0, 0, 0, 1, 0); settle();
        chk(stc_flag, 0, "R8 read clears flag");
        chk(err_out, 1, "R10 output high at read");
        run(2030);
        chk(err_out, 1, "R10 hold counted from read");
        run(30);
        chk(err_out, 0, "R10 hold expired");

        cur_req = "R8";
        stat_word = 6'h38; sync_frame(); step(0, 0, 0, 1, 0); settle();
        chk(stc_flag, 1, "R8 set beats same-cycle read");
        step(0, 0, 0, 1, 0); run(2200);

        cur_req = "R2";
        stc_report_en = 1'b0; par_report_en = 1'b0;
        step(1, 1, 1, 0, 0); settle();
        chk(err_out, 0, "R2 masked line errors");
        chk(st_par, 1, "R9 parity sticky despite mask");
        step(0, 0, 0, 0, 1); settle();
        chk(st_par | st_bip | st_len, 0, "R9 read clears sticky");
        stat_word = 6'h01; sync_frame(); step(0, 0, 0, 0, 0); run(4);
        chk(stc_flag, 1, "R2 stc set while masked");
        chk(err_out, 0, "R2 masked stc");
        step(0, 0, 0, 1, 0);
        par_report_en = 1'b1;
        step(0, 0, 1, 0, 0); settle();
        chk(err_out, 1, "R2 unmasked length error");
        cur_req = "R9";
        step(1, 0, 0, 0, 1); settle();
        chk(st_par, 1, "R9 set beats read");
        chk(st_len, 0, "R9 length cleared");
        run(2200);

        cur_req = "R3";
        serial_mode = 1'b0; par_report_en = 1'b0; stc_report_en = 1'b1;
        stat_word = 6'h3F; sync_frame(); step(0, 0, 0, 0, 0); run(4);
        chk(stc_flag, 1, "R3 stc flag up");
        chk(err_out, 0, "R3 stc ignored in parallel");
        step(0, 1, 0, 1, 0); settle();
        chk(err_out, 1, "R3 biphase despite mask");
        run(2200);
        chk(err_out, 0, "R3 expired");

        cur_req = "R2";
        serial_mode = 1'b1; unlock = 1'b1; run(5); unlock = 1'b0; settle();
        chk(err_out, 1, "R2 unlock never masked");
        chk(st_unlock, 1, "R9 unlock sticky");
        cur_req = "R5";
        pll_off = 1'b1; settle();
        chk(err_out, 0, "R5 off forces low");
        run(5); pll_off = 1'b0; run(3);
        chk(err_out, 0, "R5 hold discarded");

        cur_req = "R9";
        valid_bit = 1'b1; run(8); valid_bit = 1'b0; settle();
        chk(st_valid, 1, "R9 validity sticky");
        step(0, 0, 0, 0, 1); settle();
        chk(st_valid | st_unlock, 0, "R9 read clears");

        cur_req = "R4";
        hold_sel = 2'd3; par_report_en = 1'b1;
        step(0, 1, 0, 0, 0); run(4096 * 4 - 40);
        chk(err_out, 1, "R4 4096 hold running");
        run(80);
        chk(err_out, 0, "R4 4096 hold over");
        hold_sel = 2'd1;
        step(1, 0, 0, 0, 0); run(1024 * 4 - 40);
        chk(err_out, 1, "R4 1024 hold running");
        step(0, 0, 1, 0, 0); run(1024 * 4 - 40);
        chk(err_out, 1, "R4 retrigger restarts hold");
        run(80);
        chk(err_out, 0, "R4 1024 hold over");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule